// File: doc/BRIEF.md
# Ordered Load/Store Retirement Sequencer

This block takes a stream of memory operations and retires them strictly in the order they arrive. Each operation is either a load or a store. A load names a memory address and a destination register. A store names a memory address and a source register. A load copies a tagged word (data plus a taint bit) from a word-addressed data memory into the register file. A store copies a tagged word from the register file into memory. Every operation that completes sends one notification to an external cache-state tracker, so the tracker sees every retired access, in program order.

Operations enter through a small queue with a valid/ready handshake. The execute stage takes one operation from the head of the queue each cycle:
- A store reads the register file combinationally and writes memory at the end of that cycle.
- A load presents its address to a memory with one cycle of synchronous read latency. A retire stage writes the returned word into the register file in the following cycle.

When a store reads a register that the load just ahead of it is still writing, the returned memory word is forwarded to the store. This keeps the throughput at one operation per cycle and still lets each operation see the state left by the one before it. An operation whose address or register index is out of range is consumed and has no effect at all.

A done output tells the surrounding execution unit that the queue is empty and nothing is in flight.

Top module: `ldst_sequencer`

## Requirements
- R1: Out of reset, `done` and `op_ready` are 1, and `mem_we`, `mem_re`, `rf_we` and `cache_upd` are 0.
- R2: A load with an in-range address and register behaves as follows. `mem_re` is high with `mem_addr` equal to the address in the cycle after acceptance. In the next cycle, `rf_we` is high, `rf_wr_idx` equals the register, and `rf_wr_data` carries the memory word including its taint bit (bit `DATA_W`).
- R3: A store with an in-range address and register drives `mem_we` in the cycle after acceptance. In that cycle, `mem_addr` equals the address and `mem_wr_data` equals the source register's tagged word, taint bit included.
- R4: An operation whose register index is `NUM_REGS` or above writes no register, writes no memory and raises no cache notification.
- R5: An operation whose address is `MEM_DEPTH` or above writes no register, writes no memory and raises no cache notification.
- R6: Each completed operation raises `cache_upd` for exactly one cycle. The notification comes one cycle after the operation's execute cycle, in retirement order. `cache_is_store` (1 = store, 0 = load), `cache_addr` and `cache_reg` describe that operation.
- R7: Back-to-back operations see each other's effects. A load after a store to the same address returns the stored word. A store after a load into its source register stores the loaded word. Two loads into one register leave the later value.
- R8: No operation causes a memory write, register write or cache notification in the cycle in which it is offered to the block.
- R9: `done` is 1 exactly when the queue is empty and no load writeback or notification is pending. While `done` is 1, no memory, register or cache strobe is active.
- R10: Operations offered one per cycle are all accepted without `op_ready` falling, and the queue never holds more than `QDEPTH` entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | Queue can accept an operation |
| op_is_store | input | 1 | 1 = store, 0 = load |
| op_addr | input | ADDR_W | Memory word address |
| op_reg | input | REG_W | Register index (destination or source) |
| rf_rd_idx | output | REG_W | Register file read index |
| rf_rd_data | input | DATA_W+1 | Register file read word, taint in the top bit |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | REG_W | Register file write index |
| rf_wr_data | output | DATA_W+1 | Register file write word |
| mem_addr | output | ADDR_W | Memory address for read or write |
| mem_re | output | 1 | Memory read request (data valid next cycle) |
| mem_rd_data | input | DATA_W+1 | Memory read word, one cycle after `mem_re` |
| mem_we | output | 1 | Memory write enable |
| mem_wr_data | output | DATA_W+1 | Memory write word |
| cache_upd | output | 1 | One-cycle notification of a retired operation |
| cache_is_store | output | 1 | Kind of the retired operation |
| cache_addr | output | ADDR_W | Address of the retired operation |
| cache_reg | output | REG_W | Register of the retired operation |
| done | output | 1 | Queue empty and nothing in flight |

## Verification
The bench builds the block with `DATA_W=8`, `ADDR_W=5`, `MEM_DEPTH=16`, `REG_W=4`, `NUM_REGS=8` and `QDEPTH=4`. Half of the address space and half of the register index space therefore lie out of range. This lets the sweeps cover every address against every register index for both kinds, and every in-range or out-of-range combination. The small register file and memory are compared entry by entry against an arithmetic model after each batch. The cumulative notification log is checked entry by entry. Dense back-to-back sequences over so few locations hit the store-then-load, load-then-store forwarding and load-then-load cases many times over, and a dedicated timing segment pins down the exact cycle of every strobe.

// File: rtl/ldst_pkg.sv
// Shared types for the load/store sequencer.
package ldst_pkg;

    // Operation kind; the encoding is what op_is_store / cache_is_store carry.
    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } ldst_kind_e;

endpackage

// File: rtl/ldst_op_fifo.sv
// Operation queue: a DEPTH-entry first-in first-out buffer with a valid/ready
// write side and a pop strobe on the read side.
// Assumes pop is only meaningful while out_valid is high.
module ldst_op_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    input  logic             pop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push, take;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Handshake decode.
    always_comb begin
        in_ready  = (count != CNT_W'(DEPTH));
        out_valid = (count != '0);
        push      = in_valid && in_ready;
        take      = pop && out_valid;
        out_data  = slots[rd_ptr];
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= in_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (take) rd_ptr <= next_ptr(rd_ptr);
            case ({push, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R10
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= DEPTH);

    // R10
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !take) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/ldst_issue.sv
// Execute stage: decodes the queue head, checks range, drives the memory port
// and the register read port, and hands the operation to the retire stage.
// Assumes memory reads return one cycle after mem_re and register reads are
// combinational. A store whose source register is being written this cycle
// by the preceding load takes the forwarded memory word.
module ldst_issue
    import ldst_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 10,
    parameter int REG_W     = 5,
    parameter int MEM_DEPTH = 1000,
    parameter int NUM_REGS  = 24
) (
    input  logic              head_valid,
    input  ldst_kind_e        head_kind,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [REG_W-1:0]  head_reg,
    input  logic [DATA_W:0]   rf_rd_data,
    input  logic [DATA_W:0]   mem_rd_data,
    input  logic              fwd_valid,
    input  logic [REG_W-1:0]  fwd_reg,
    output logic              pop,
    output logic [REG_W-1:0]  rf_rd_idx,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W:0]   mem_wr_data,
    output logic              iss_valid,
    output ldst_kind_e        iss_kind,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [REG_W-1:0]  iss_reg
);
    logic addr_ok, reg_ok, fire;

    // Range check and port decode for the head operation.
    always_comb begin
        addr_ok     = 32'(head_addr) < MEM_DEPTH;
        reg_ok      = 32'(head_reg) < NUM_REGS;
        fire        = head_valid && addr_ok && reg_ok;
        pop         = head_valid;
        rf_rd_idx   = head_reg;
        mem_addr    = head_addr;
        mem_re      = fire && (head_kind == KIND_LOAD);
        mem_we      = fire && (head_kind == KIND_STORE);
        mem_wr_data = (fwd_valid && (fwd_reg == head_reg)) ? mem_rd_data : rf_rd_data;
        iss_valid   = fire;
        iss_kind    = head_kind;
        iss_addr    = head_addr;
        iss_reg     = head_reg;
    end
endmodule

// File: rtl/ldst_retire.sv
// Retire stage: holds the operation issued last cycle, completes load
// writebacks with the returned memory word and raises the cache notification.
// Assumes the memory word for a load arrives in this stage's cycle.
module ldst_retire
    import ldst_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 10,
    parameter int REG_W    = 5,
    parameter int NUM_REGS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  ldst_kind_e        iss_kind,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [REG_W-1:0]  iss_reg,
    input  logic [DATA_W:0]   mem_rd_data,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_wr_idx,
    output logic [DATA_W:0]   rf_wr_data,
    output logic              cache_upd,
    output logic              cache_is_store,
    output logic [ADDR_W-1:0] cache_addr,
    output logic [REG_W-1:0]  cache_reg,
    output logic              fwd_valid,
    output logic [REG_W-1:0]  fwd_reg,
    output logic              busy
);
    logic              w_valid;
    ldst_kind_e        w_kind;
    logic [ADDR_W-1:0] w_addr;
    logic [REG_W-1:0]  w_reg;

    // Stage register; only the valid bit needs reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_valid <= 1'b0;
            w_kind  <= KIND_LOAD;
            w_addr  <= '0;
            w_reg   <= '0;
        end else begin
            w_valid <= iss_valid;
            w_kind  <= iss_kind;
            w_addr  <= iss_addr;
            w_reg   <= iss_reg;
        end
    end

    // Writeback, notification and forwarding outputs.
    always_comb begin
        rf_we          = w_valid && (w_kind == KIND_LOAD);
        rf_wr_idx      = w_reg;
        rf_wr_data     = mem_rd_data;
        cache_upd      = w_valid;
        cache_is_store = (w_kind == KIND_STORE);
        cache_addr     = w_addr;
        cache_reg      = w_reg;
        fwd_valid      = rf_we;
        fwd_reg        = w_reg;
        busy           = w_valid;
    end

    // R4
    wr_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (32'(rf_wr_idx) < NUM_REGS));
endmodule

// File: rtl/ldst_sequencer.sv
// Top of the load/store retirement sequencer: queue, execute stage and retire
// stage. One operation leaves the queue per cycle; loads retire one cycle
// after their memory read, stores write memory in their execute cycle and
// notify the cache tracker one cycle later, so notifications stay in order.
// Assumes an external register file with combinational read and a memory
// with one-cycle synchronous read.
module ldst_sequencer
    import ldst_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 10,
    parameter int MEM_DEPTH = 1000,
    parameter int REG_W     = 5,
    parameter int NUM_REGS  = 24,
    parameter int QDEPTH    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_is_store,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [REG_W-1:0]  op_reg,
    output logic [REG_W-1:0]  rf_rd_idx,
    input  logic [DATA_W:0]   rf_rd_data,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_wr_idx,
    output logic [DATA_W:0]   rf_wr_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    input  logic [DATA_W:0]   mem_rd_data,
    output logic              mem_we,
    output logic [DATA_W:0]   mem_wr_data,
    output logic              cache_upd,
    output logic              cache_is_store,
    output logic [ADDR_W-1:0] cache_addr,
    output logic [REG_W-1:0]  cache_reg,
    output logic              done
);
    localparam int OP_W = 1 + ADDR_W + REG_W;

    logic [OP_W-1:0]   in_word, head_word;
    logic              head_valid, pop;
    ldst_kind_e        head_kind;
    logic [ADDR_W-1:0] head_addr;
    logic [REG_W-1:0]  head_reg;
    logic              iss_valid;
    ldst_kind_e        iss_kind;
    logic [ADDR_W-1:0] iss_addr;
    logic [REG_W-1:0]  iss_reg;
    logic              fwd_valid, ret_busy;
    logic [REG_W-1:0]  fwd_reg;

    // Pack the incoming operation and unpack the queue head.
    always_comb begin
        in_word   = {op_is_store, op_addr, op_reg};
        head_kind = ldst_kind_e'(head_word[OP_W-1]);
        head_addr = head_word[REG_W +: ADDR_W];
        head_reg  = head_word[REG_W-1:0];
        done      = !head_valid && !ret_busy;
    end

    ldst_op_fifo #(.WIDTH(OP_W), .DEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (op_valid),
        .in_ready  (op_ready),
        .in_data   (in_word),
        .out_valid (head_valid),
        .out_data  (head_word),
        .pop       (pop)
    );

    ldst_issue #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W),
        .MEM_DEPTH(MEM_DEPTH), .NUM_REGS(NUM_REGS)
    ) u_issue (
        .head_valid  (head_valid),
        .head_kind   (head_kind),
        .head_addr   (head_addr),
        .head_reg    (head_reg),
        .rf_rd_data  (rf_rd_data),
        .mem_rd_data (mem_rd_data),
        .fwd_valid   (fwd_valid),
        .fwd_reg     (fwd_reg),
        .pop         (pop),
        .rf_rd_idx   (rf_rd_idx),
        .mem_addr    (mem_addr),
        .mem_re      (mem_re),
        .mem_we      (mem_we),
        .mem_wr_data (mem_wr_data),
        .iss_valid   (iss_valid),
        .iss_kind    (iss_kind),
        .iss_addr    (iss_addr),
        .iss_reg     (iss_reg)
    );

    ldst_retire #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS)
    ) u_retire (
        .clk            (clk),
        .rst_n          (rst_n),
        .iss_valid      (iss_valid),
        .iss_kind       (iss_kind),
        .iss_addr       (iss_addr),
        .iss_reg        (iss_reg),
        .mem_rd_data    (mem_rd_data),
        .rf_we          (rf_we),
        .rf_wr_idx      (rf_wr_idx),
        .rf_wr_data     (rf_wr_data),
        .cache_upd      (cache_upd),
        .cache_is_store (cache_is_store),
        .cache_addr     (cache_addr),
        .cache_reg      (cache_reg),
        .fwd_valid      (fwd_valid),
        .fwd_reg        (fwd_reg),
        .busy           (ret_busy)
    );

    // R2
    load_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(mem_re));

    // R5
    mem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (32'(mem_addr) < MEM_DEPTH));

    // R6
    store_note_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_upd && cache_is_store) |-> ($past(mem_we) && ($past(mem_addr) == cache_addr)));

    // R6
    load_note_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (cache_upd && !cache_is_store && (cache_reg == rf_wr_idx)));

    // R8
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_upd |-> !$past(done));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(mem_we || mem_re || rf_we || cache_upd));
endmodule

// File: tb/ldst_sequencer_test.sv
module ldst_sequencer_test;
    localparam int DW = 8;
    localparam int AW = 5;
    localparam int MD = 16;
    localparam int RW = 4;
    localparam int NR = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic          op_is_store = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [RW-1:0] op_reg = '0;
    logic [RW-1:0] rf_rd_idx;
    logic [DW:0]   rf_rd_data;
    logic          rf_we;
    logic [RW-1:0] rf_wr_idx;
    logic [DW:0]   rf_wr_data;
    logic [AW-1:0] mem_addr;
    logic          mem_re;
    logic [DW:0]   mem_rd_data;
    logic          mem_we;
    logic [DW:0]   mem_wr_data;
    logic          cache_upd, cache_is_store;
    logic [AW-1:0] cache_addr;
    logic [RW-1:0] cache_reg;
    logic          done;

    always #2 clk = ~clk;

    ldst_sequencer #(
        .DATA_W(DW), .ADDR_W(AW), .MEM_DEPTH(MD),
        .REG_W(RW), .NUM_REGS(NR), .QDEPTH(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_is_store(op_is_store), .op_addr(op_addr), .op_reg(op_reg),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
        .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_rd_data(mem_rd_data), .mem_we(mem_we),
        .mem_wr_data(mem_wr_data), .cache_upd(cache_upd),
        .cache_is_store(cache_is_store), .cache_addr(cache_addr),
        .cache_reg(cache_reg), .done(done)
    );

    // Register file and memory models around the block.
    logic [DW:0] rf_m [NR];
    logic [DW:0] mem_m [MD];
    logic [DW:0] mem_q;
    logic        seed_en = 1'b0;

    function automatic logic [DW:0] rf_seed(input int i);
        return {i[0], 8'(8'h30 + i)};
    endfunction
    function automatic logic [DW:0] mem_seed(input int a);
        return {a[1] ^ a[0], 8'(8'hC0 + 3 * a)};
    endfunction

    assign rf_rd_data  = (32'(rf_rd_idx) < NR) ? rf_m[rf_rd_idx[2:0]] : '0;
    assign mem_rd_data = mem_q;

    always @(posedge clk) begin
        if (seed_en) begin
            for (int i = 0; i < NR; i++) rf_m[i] <= rf_seed(i);
            for (int a = 0; a < MD; a++) mem_m[a] <= mem_seed(a);
        end else begin
            if (rf_we && 32'(rf_wr_idx) < NR) rf_m[rf_wr_idx[2:0]] <= rf_wr_data;
            if (mem_we && 32'(mem_addr) < MD) mem_m[mem_addr[3:0]] <= mem_wr_data;
        end
        if (mem_re) mem_q <= (32'(mem_addr) < MD) ? mem_m[mem_addr[3:0]] : '0;
    end

    // Notification log and out-of-range strobe monitor.
    int   log_n = 0;
    logic log_st [4096];
    int   log_a  [4096];
    int   log_r  [4096];
    int   mon_checks = 0;
    int   mon_errs = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cache_upd && log_n < 4096) begin
                log_st[log_n] = cache_is_store;
                log_a[log_n]  = int'(cache_addr);
                log_r[log_n]  = int'(cache_reg);
                log_n = log_n + 1;
            end
            if (rf_we) begin
                mon_checks++;
                if (32'(rf_wr_idx) >= NR) begin
                    mon_errs++;
                    $display("FAIL R4: rf write idx actual=%0d expected<%0d", rf_wr_idx, NR);
                end
            end
            if (mem_we) begin
                mon_checks++;
                if (32'(mem_addr) >= MD) begin
                    mon_errs++;
                    $display("FAIL R5: mem write addr actual=%0d expected<%0d", mem_addr, MD);
                end
            end
        end
    end

    // Expected state.
    logic [DW:0] exp_rf [NR];
    logic [DW:0] exp_mem [MD];
    int   exp_n = 0;
    logic exp_st [4096];
    int   exp_a  [4096];
    int   exp_r  [4096];
    int   seen_n = 0;
    int   checks = 0;
    int   errors = 0;

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic apply_exp(input logic st, input int a, input int r);
        if (a < MD && r < NR) begin
            if (st) exp_mem[a] = exp_rf[r];
            else    exp_rf[r]  = exp_mem[a];
            exp_st[exp_n] = st;
            exp_a[exp_n]  = a;
            exp_r[exp_n]  = r;
            exp_n++;
        end
    endtask

    // Offer one operation at a negedge and let it be accepted at the next edge.
    task automatic push_op(input logic st, input int a, input int r);
        op_valid    = 1'b1;
        op_is_store = st;
        op_addr     = AW'(a);
        op_reg      = RW'(r);
        chk(op_ready == 1'b1, "R10", "op_ready while streaming", int'(op_ready), 1);
        apply_exp(st, a, r);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R9", "done after drain", int'(done), 1);
    endtask

    task automatic check_all(input string req_rf, input string req_mem);
        wait_done();
        for (int i = 0; i < NR; i++)
            chk(rf_m[i] == exp_rf[i], req_rf, $sformatf("rf[%0d]", i), int'(rf_m[i]), int'(exp_rf[i]));
        for (int a = 0; a < MD; a++)
            chk(mem_m[a] == exp_mem[a], req_mem, $sformatf("mem[%0d]", a), int'(mem_m[a]), int'(exp_mem[a]));
        chk(log_n == exp_n, "R6", "notification count", log_n, exp_n);
        for (int k = seen_n; k < exp_n && k < log_n; k++) begin
            chk(log_st[k] == exp_st[k], "R6", $sformatf("note %0d kind", k), int'(log_st[k]), int'(exp_st[k]));
            chk(log_a[k] == exp_a[k], "R6", $sformatf("note %0d addr", k), log_a[k], exp_a[k]);
            chk(log_r[k] == exp_r[k], "R6", $sformatf("note %0d reg", k), log_r[k], exp_r[k]);
        end
        seen_n = exp_n;
    endtask

    task automatic reseed();
        seed_en = 1'b1;
        @(negedge clk);
        seed_en = 1'b0;
        for (int i = 0; i < NR; i++) exp_rf[i] = rf_seed(i);
        for (int a = 0; a < MD; a++) exp_mem[a] = mem_seed(a);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R9: watchdog expired actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors + mon_errs + 1, checks + mon_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(done == 1'b1, "R1", "done after reset", int'(done), 1);
        chk(op_ready == 1'b1, "R1", "op_ready after reset", int'(op_ready), 1);
        chk({mem_we, mem_re, rf_we, cache_upd} == 4'b0, "R1", "strobes after reset",
            int'({mem_we, mem_re, rf_we, cache_upd}), 0);
        reseed();

        // Exact timing of one store then one load from idle.
        op_valid = 1'b1; op_is_store = 1'b1; op_addr = 5'd2; op_reg = 4'd1;
        chk(!mem_we && !cache_upd, "R8", "store strobes in offer cycle", int'({mem_we, cache_upd}), 0);
        apply_exp(1'b1, 2, 1);
        @(negedge clk); op_valid = 1'b0;
        chk(mem_we && mem_addr == 5'd2, "R3", "store mem_we/addr", int'({mem_we, mem_addr}), int'({1'b1, 5'd2}));
        chk(mem_wr_data == exp_rf[1], "R3", "store data with taint", int'(mem_wr_data), int'(exp_rf[1]));
        chk(done == 1'b0, "R9", "done while store in flight", int'(done), 0);
        @(negedge clk);
        chk(cache_upd && cache_is_store && cache_addr == 5'd2 && cache_reg == 4'd1, "R6",
            "store notification", int'({cache_upd, cache_is_store, cache_addr, cache_reg}),
            int'({1'b1, 1'b1, 5'd2, 4'd1}));
        @(negedge clk);
        chk(done == 1'b1, "R9", "done after store retires", int'(done), 1);
        op_valid = 1'b1; op_is_store = 1'b0; op_addr = 5'd3; op_reg = 4'd4;
        chk(!mem_re && !rf_we, "R8", "load strobes in offer cycle", int'({mem_re, rf_we}), 0);
        apply_exp(1'b0, 3, 4);
        @(negedge clk); op_valid = 1'b0;
        chk(mem_re && mem_addr == 5'd3 && !rf_we, "R2", "load read cycle",
            int'({mem_re, mem_addr, rf_we}), int'({1'b1, 5'd3, 1'b0}));
        @(negedge clk);
        chk(rf_we && rf_wr_idx == 4'd4, "R2", "load writeback idx", int'({rf_we, rf_wr_idx}), int'({1'b1, 4'd4}));
        chk(rf_wr_data == exp_mem[3], "R2", "load data with taint", int'(rf_wr_data), int'(exp_mem[3]));
        chk(cache_upd && !cache_is_store, "R6", "load notification", int'({cache_upd, cache_is_store}), 2);
        check_all("R2", "R3");

        // Back-to-back ordering cases (R7).
        reseed();
        push_op(1'b1, 5, 0);   // store r0 -> m5
        push_op(1'b0, 5, 3);   // load m5 -> r3 (sees store)
        push_op(1'b1, 7, 3);   // store r3 -> m7 (forwarded load word)
        push_op(1'b0, 6, 2);
        push_op(1'b0, 9, 2);   // two loads into r2, later wins
        push_op(1'b1, 8, 2);   // forwarded again
        push_op(1'b0, 8, 6);
        check_all("R7", "R7");

        // Out-of-range operations only (R4, R5).
        reseed();
        push_op(1'b1, 20, 1);
        push_op(1'b0, 3, 9);
        push_op(1'b1, 31, 15);
        push_op(1'b0, 16, 2);
        push_op(1'b1, 4, 8);
        check_all("R4 R5", "R4 R5");

        // Store sweep: every address against every register index.
        reseed();
        for (int a = 0; a < 32; a++) begin
            for (int r = 0; r < 16; r++) push_op(1'b1, a, r);
            check_all("R3 R4 R5", "R3 R4 R5");
        end

        // Load sweep.
        reseed();
        for (int a = 0; a < 32; a++) begin
            for (int r = 0; r < 16; r++) push_op(1'b0, a, 15 - r);
            check_all("R2 R4 R5", "R2 R4 R5");
        end

        // Mixed dense sweep exercising every ordering pair.
        reseed();
        for (int i = 0; i < 512; i++) begin
            push_op(((i * 3) % 5) < 2, (i * 7) % 32, (i * 5) % 16);
            if (i % 32 == 31) check_all("R2 R7", "R3 R7");
        end

        $display("  Result: errors=%0d of %0d checks", errors + mon_errs, checks + mon_checks);
        $finish;
    end
endmodule